// File: doc/BRIEF.md
# ADC Conversion Queue Sequencer

This block drives an external analog-to-digital converter from two independent command queues that share one 64-entry command space and one 64-entry result space. Each command entry names a channel, a sample-time code and a pause bit. When a queue is started, the sequencer walks its entries in order. For each entry it raises a conversion request that carries the channel and sample-time code, waits for the converter's done strobe, and stores the 10-bit result at the same index in the result space. Software reads any result in one of three alignments.

Queue 1 owns indices 0 up to the boundary `q2_begin`, and queue 2 owns `q2_begin` up to 63. A queue ends at the first entry whose channel is the all-ones end code, or at the end of its region. Each queue has its own trigger source: a software pulse, a rising edge on its external pin, a level gate on that pin, or a tick from an interval timer that both queues share. Queue 1 always wins the converter. A queue 1 start that arrives while queue 2 is converting takes effect once the conversion in flight has finished, and queue 2 then continues from where it stopped. Each queue has a complete flag and a pause flag, and either can drive that queue's interrupt line. A trigger that arrives while its queue is already running sets an overrun flag and has no other effect.

Top module: `adc_queue_seq`

## Requirements
- R1: After reset, conv_req is low, all flags and interrupts are 0, and both queue pointers read 0.
- R2: In software mode (mode code 0), an sw_go pulse starts the queue at offset 0. Entries are converted in index order. An entry with channel 63 is not converted. Reaching it sets the queue's complete flag and returns the pointer to 0.
- R3: Queue 1 covers indices 0 to q2_begin-1 and queue 2 covers q2_begin to 63. A queue that reaches the end of its region without an end code completes just as it would at an end code. The pointer outputs give the offset from the queue's first index.
- R4: An entry whose pause bit is set is converted. The queue then stops with its pause flag set and its pointer on the following entry. The next trigger resumes from that entry.
- R5: Queue 1 has priority. A queue 1 start that arrives during a queue 2 conversion is served right after that conversion, and queue 2 then resumes at its next entry.
- R6: In edge mode (code 1), a rising edge on the queue's ext_trig bit starts the queue. Holding the pin high does not restart the queue, and sw_go is ignored.
- R7: In gate mode (code 2), the queue runs and restarts after each completion for as long as its ext_trig bit is high. When the pin goes low, the queue stops after the conversion in flight.
- R8: In timer mode (code 3), the queue starts on each tick of the shared timer. A tick occurs every tmr_period cycles, and a period of 0 stops the timer.
- R9: A trigger that arrives while its queue is active sets that queue's overrun flag. It does not change the sequence of conversions.
- R10: rd_data shows result rd_addr in one of three alignments. rd_fmt 0 gives the value right-justified with zero fill. rd_fmt 1 gives it left-justified, with bits 15:6 holding the value. rd_fmt 2 gives it left-justified as a signed value, which is the result minus 512 placed in bits 15:6.
- R11: conv_req stays high, and conv_chan and conv_stime stay stable, until conv_done. conv_stime equals the sample-time field of the entry being converted.
- R12: irq[q] is (complete & cf_ie) | (pause & pf_ie) for queue q. flag_clr[q] clears all three flags of queue q.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_we | input | 1 | Command entry write strobe |
| cmd_addr | input | 6 | Command entry index |
| cmd_wchan | input | 6 | Channel to write; 63 marks end of queue |
| cmd_wstime | input | 2 | Sample-time code to write |
| cmd_wpause | input | 1 | Pause bit to write |
| q2_begin | input | 6 | First index of queue 2 |
| q_mode | input | 4 | Trigger mode, bits 1:0 queue 1, bits 3:2 queue 2 |
| sw_go | input | 2 | Software start pulses, one per queue |
| ext_trig | input | 2 | External trigger or gate pins, one per queue |
| tmr_period | input | 16 | Interval timer period in cycles, 0 stops it |
| flag_clr | input | 2 | Clear flags of queue 1 / queue 2 |
| cf_ie | input | 2 | Complete interrupt enables |
| pf_ie | input | 2 | Pause interrupt enables |
| conv_req | output | 1 | Conversion request to converter |
| conv_chan | output | 6 | Channel for the request |
| conv_stime | output | 2 | Sample-time code for the request |
| conv_done | input | 1 | Converter finished, conv_data valid |
| conv_data | input | 10 | Conversion result |
| rd_addr | input | 6 | Result index to read |
| rd_fmt | input | 2 | Result alignment select |
| rd_data | output | 16 | Formatted result |
| q1_ptr | output | 7 | Queue 1 current offset |
| q2_ptr | output | 7 | Queue 2 current offset |
| cmpl_flag | output | 2 | Queue complete flags |
| pause_flag | output | 2 | Queue pause flags |
| ovr_flag | output | 2 | Trigger overrun flags |
| irq | output | 2 | Interrupt lines per queue |

## Verification
The hardest state to reach from the ports is a queue 1 start that lands while a queue 2 conversion is in flight. To get there, the bench's converter model stretches each conversion according to its sample-time code. The bench starts queue 2, waits until it sees the request for queue 2's first entry, and only then pulses queue 1's start, so that the logged channel order exposes the preemption point. The gate case is reached the same way: the pin is dropped while a conversion is in flight, and the bench confirms that no new request follows.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
   typedef enum logic [1:0] {
      TRG_SOFT  = 2'd0,
      TRG_EDGE  = 2'd1,
      TRG_GATE  = 2'd2,
      TRG_TIMER = 2'd3
   } trig_mode_e;

   typedef enum logic [1:0] {
      FMT_RJ  = 2'd0,
      FMT_LJ  = 2'd1,
      FMT_LJS = 2'd2,
      FMT_RSV = 2'd3
   } res_fmt_e;
endpackage

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
   parameter int TMR_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [TMR_W-1:0] period,
   output logic             tick
);
   logic [TMR_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt  <= '0;
         tick <= 1'b0;
      end else if (period == '0) begin
         cnt  <= '0;
         tick <= 1'b0;
      end else if (cnt >= period - 1'b1) begin
         cnt  <= '0;
         tick <= 1'b1;
      end else begin
         cnt  <= cnt + 1'b1;
         tick <= 1'b0;
      end
   end

   // R8
   tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && period > 1) |=> !tick);
endmodule

// File: rtl/adc_seq_trig.sv
module adc_seq_trig
   import adc_seq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] mode,
   input  logic       sw_go,
   input  logic       ext_in,
   input  logic       tick,
   input  logic       act_in,
   output logic       start,
   output logic       overrun,
   output logic       halt
);
   trig_mode_e m;
   logic       ext_q, rise, req;

   assign m = trig_mode_e'(mode);

   always_ff @(posedge clk) begin
      if (!rst_n) ext_q <= 1'b1;
      else        ext_q <= ext_in;
   end

   assign rise    = ext_in & ~ext_q;
   assign req     = ((m == TRG_SOFT) & sw_go) | ((m == TRG_EDGE) & rise)
                  | ((m == TRG_TIMER) & tick);
   assign start   = ~act_in & (req | ((m == TRG_GATE) & ext_in));
   assign overrun = act_in & req;
   assign halt    = (m == TRG_GATE) & ~ext_in;

   // R6
   edge_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (m == TRG_EDGE && start) |-> !$past(ext_in));
endmodule

// File: rtl/adc_seq_fmt.sv
module adc_seq_fmt
   import adc_seq_pkg::*;
#(
   parameter int RES_W = 10,
   parameter int OUT_W = 16
) (
   input  logic [RES_W-1:0] res,
   input  logic [1:0]       fmt,
   output logic [OUT_W-1:0] out
);
   localparam int PAD = OUT_W - RES_W;
   logic [RES_W-1:0] sgn;

   assign sgn = {~res[RES_W-1], res[RES_W-2:0]};

   generate
      if (PAD < 0) begin : g_bad
         $error("adc_seq_fmt: OUT_W must not be below RES_W");
      end else if (PAD == 0) begin : g_flush
         always_comb begin
            case (res_fmt_e'(fmt))
               FMT_LJS: out = sgn;
               default: out = res;
            endcase
         end
      end else begin : g_pad
         always_comb begin
            case (res_fmt_e'(fmt))
               FMT_LJ:  out = {res, {PAD{1'b0}}};
               FMT_LJS: out = {sgn, {PAD{1'b0}}};
               default: out = {{PAD{1'b0}}, res};
            endcase
         end
      end
   endgenerate
endmodule

// File: rtl/adc_queue_seq.sv
module adc_queue_seq
   import adc_seq_pkg::*;
#(
   parameter int AW    = 6,
   parameter int CH_W  = 6,
   parameter int ST_W  = 2,
   parameter int RES_W = 10,
   parameter int OUT_W = 16,
   parameter int TMR_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_we,
   input  logic [AW-1:0]    cmd_addr,
   input  logic [CH_W-1:0]  cmd_wchan,
   input  logic [ST_W-1:0]  cmd_wstime,
   input  logic             cmd_wpause,
   input  logic [AW-1:0]    q2_begin,
   input  logic [3:0]       q_mode,
   input  logic [1:0]       sw_go,
   input  logic [1:0]       ext_trig,
   input  logic [TMR_W-1:0] tmr_period,
   input  logic [1:0]       flag_clr,
   input  logic [1:0]       cf_ie,
   input  logic [1:0]       pf_ie,
   output logic             conv_req,
   output logic [CH_W-1:0]  conv_chan,
   output logic [ST_W-1:0]  conv_stime,
   input  logic             conv_done,
   input  logic [RES_W-1:0] conv_data,
   input  logic [AW-1:0]    rd_addr,
   input  logic [1:0]       rd_fmt,
   output logic [OUT_W-1:0] rd_data,
   output logic [AW:0]      q1_ptr,
   output logic [AW:0]      q2_ptr,
   output logic [1:0]       cmpl_flag,
   output logic [1:0]       pause_flag,
   output logic [1:0]       ovr_flag,
   output logic [1:0]       irq
);
   localparam int DEPTH = 1 << AW;
   localparam int PW    = AW + 1;
   localparam logic [CH_W-1:0] EOQ = {CH_W{1'b1}};

   typedef struct packed {
      logic            pause;
      logic [ST_W-1:0] st;
      logic [CH_W-1:0] ch;
   } cmd_t;

   generate
      if (CH_W < 2 || ST_W < 1 || RES_W < 2 || AW < 2) begin : g_chk
         $error("adc_queue_seq: field widths too small");
      end
   endgenerate

   cmd_t            cmd_mem [DEPTH];
   logic [RES_W-1:0] res_mem [DEPTH];
   logic [PW-1:0]   base [2];
   logic [PW-1:0]   len  [2];
   logic [PW-1:0]   off  [2];
   logic [1:0]      act, start, ovr_ev, halt;
   logic            busy, cur_q, tick;
   logic            sel_v, sel_q, sel_end;
   logic [AW-1:0]   sel_idx, cur_idx;

   assign base[0] = '0;
   assign base[1] = PW'(q2_begin);
   assign len[0]  = PW'(q2_begin);
   assign len[1]  = PW'(DEPTH) - PW'(q2_begin);

   adc_seq_timer #(.TMR_W(TMR_W)) u_tmr (
      .clk(clk), .rst_n(rst_n), .period(tmr_period), .tick(tick)
   );

   generate
      for (genvar g = 0; g < 2; g++) begin : g_q
         adc_seq_trig u_trig (
            .clk(clk), .rst_n(rst_n), .mode(q_mode[2*g+1:2*g]),
            .sw_go(sw_go[g]), .ext_in(ext_trig[g]), .tick(tick),
            .act_in(act[g]), .start(start[g]), .overrun(ovr_ev[g]),
            .halt(halt[g])
         );
         // R4
         pause_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pause_flag[g]) |-> $past(conv_done));
      end
   endgenerate

   // queue 1 first whenever it is active
   assign sel_v   = act[0] | act[1];
   assign sel_q   = ~act[0];
   assign sel_idx = AW'(base[sel_q] + off[sel_q]);
   assign sel_end = (off[sel_q] >= len[sel_q]) || (cmd_mem[sel_idx].ch == EOQ);
   assign cur_idx = AW'(base[cur_q] + off[cur_q]);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) begin
            cmd_mem[i] <= '0;
            res_mem[i] <= '0;
         end
         for (int q = 0; q < 2; q++) off[q] <= '0;
         act        <= '0;
         busy       <= 1'b0;
         cur_q      <= 1'b0;
         conv_req   <= 1'b0;
         conv_chan  <= '0;
         conv_stime <= '0;
         cmpl_flag  <= '0;
         pause_flag <= '0;
         ovr_flag   <= '0;
      end else begin
         if (cmd_we) cmd_mem[cmd_addr] <= '{pause: cmd_wpause, st: cmd_wstime, ch: cmd_wchan};
         for (int q = 0; q < 2; q++) begin
            if (flag_clr[q]) begin
               cmpl_flag[q]  <= 1'b0;
               pause_flag[q] <= 1'b0;
               ovr_flag[q]   <= 1'b0;
            end
            if (ovr_ev[q]) ovr_flag[q] <= 1'b1;
            if (start[q])  act[q]      <= 1'b1;
         end
         if (!busy) begin
            if (sel_v) begin
               if (halt[sel_q]) begin
                  act[sel_q] <= 1'b0;
               end else if (sel_end) begin
                  cmpl_flag[sel_q] <= 1'b1;
                  act[sel_q]       <= 1'b0;
                  off[sel_q]       <= '0;
               end else begin
                  conv_req   <= 1'b1;
                  conv_chan  <= cmd_mem[sel_idx].ch;
                  conv_stime <= cmd_mem[sel_idx].st;
                  cur_q      <= sel_q;
                  busy       <= 1'b1;
               end
            end
         end else if (conv_done) begin
            conv_req         <= 1'b0;
            busy             <= 1'b0;
            res_mem[cur_idx] <= conv_data;
            off[cur_q]       <= off[cur_q] + 1'b1;
            if (cmd_mem[cur_idx].pause) begin
               pause_flag[cur_q] <= 1'b1;
               act[cur_q]        <= 1'b0;
            end
         end
      end
   end

   adc_seq_fmt #(.RES_W(RES_W), .OUT_W(OUT_W)) u_fmt (
      .res(res_mem[rd_addr]), .fmt(rd_fmt), .out(rd_data)
   );

   assign q1_ptr = off[0];
   assign q2_ptr = off[1];
   assign irq    = (cmpl_flag & cf_ie) | (pause_flag & pf_ie);

   // R11
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_req && !conv_done) |=> conv_req);
   // R11
   chan_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_req && !conv_done) |=> ($stable(conv_chan) && $stable(conv_stime)));
   // R2
   no_eoq_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
      conv_req |-> (conv_chan != EOQ));
   // R5
   prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(conv_req) && cur_q) |-> !$past(act[0]));
endmodule

// File: tb/adc_queue_seq_tb.sv
`timescale 1ns/1ps
module adc_queue_seq_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_we = 1'b0;
   logic [5:0]  cmd_addr = '0, cmd_wchan = '0, q2_begin = '0, rd_addr = '0;
   logic [1:0]  cmd_wstime = '0, rd_fmt = '0;
   logic        cmd_wpause = 1'b0;
   logic [3:0]  q_mode = '0;
   logic [1:0]  sw_go = '0, ext_trig = '0, flag_clr = '0, cf_ie = '0, pf_ie = '0;
   logic [15:0] tmr_period = '0;
   logic        conv_req, conv_done = 1'b0;
   logic [5:0]  conv_chan;
   logic [1:0]  conv_stime;
   logic [9:0]  conv_data = '0;
   logic [15:0] rd_data;
   logic [6:0]  q1_ptr, q2_ptr;
   logic [1:0]  cmpl_flag, pause_flag, ovr_flag, irq;

   always #4 clk = ~clk;

   adc_queue_seq u_dut (
      .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_addr(cmd_addr),
      .cmd_wchan(cmd_wchan), .cmd_wstime(cmd_wstime), .cmd_wpause(cmd_wpause),
      .q2_begin(q2_begin), .q_mode(q_mode), .sw_go(sw_go), .ext_trig(ext_trig),
      .tmr_period(tmr_period), .flag_clr(flag_clr), .cf_ie(cf_ie), .pf_ie(pf_ie),
      .conv_req(conv_req), .conv_chan(conv_chan), .conv_stime(conv_stime),
      .conv_done(conv_done), .conv_data(conv_data), .rd_addr(rd_addr),
      .rd_fmt(rd_fmt), .rd_data(rd_data), .q1_ptr(q1_ptr), .q2_ptr(q2_ptr),
      .cmpl_flag(cmpl_flag), .pause_flag(pause_flag), .ovr_flag(ovr_flag), .irq(irq)
   );

   int total = 0, bad = 0;
   int nlog = 0;
   int log_ch [1024];
   int log_st [1024];
   int bch [64], bst [64], exp_res [64];
   int eo [512];

   function automatic int dat(int k);
      case (k % 4)
         0: return 0;
         1: return 1023;
         2: return 512;
         default: return (k * 181 + 77) % 1024;
      endcase
   endfunction

   task automatic chk(string req, int actv, int expv);
      total++;
      if (actv != expv) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, actv, expv);
      end
   endtask

   // converter model: latency 2 + sample-time code
   initial begin : conv_model
      int lat, cur_ch;
      bit in_conv;
      in_conv = 0; lat = 0; cur_ch = 0;
      forever begin
         @(negedge clk);
         if (conv_done) conv_done = 1'b0;
         else if (in_conv) begin
            chk("R11 chan held", int'(conv_chan), cur_ch);
            lat--;
            if (lat <= 0) begin
               conv_done = 1'b1;
               conv_data = 10'(dat(nlog - 1));
               in_conv = 0;
            end
         end else if (conv_req) begin
            log_ch[nlog] = int'(conv_chan);
            log_st[nlog] = int'(conv_stime);
            nlog++;
            lat = 2 + int'(conv_stime);
            cur_ch = int'(conv_chan);
            in_conv = 1;
         end
      end
   end

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   task automatic cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(int a, int ch, int st, bit p);
      @(negedge clk);
      cmd_we = 1; cmd_addr = 6'(a); cmd_wchan = 6'(ch); cmd_wstime = 2'(st); cmd_wpause = p;
      @(negedge clk);
      cmd_we = 0;
      bch[a] = ch; bst[a] = st;
   endtask

   task automatic go(int q);
      @(negedge clk); sw_go[q] = 1'b1;
      @(negedge clk); sw_go[q] = 1'b0;
   endtask

   task automatic clr(int q);
      @(negedge clk); flag_clr[q] = 1'b1;
      @(negedge clk); flag_clr[q] = 1'b0;
   endtask

   task automatic wait_cmpl(int q);
      int t = 0;
      while (!cmpl_flag[q] && t < 3000) begin @(negedge clk); t++; end
      cyc(2);
   endtask

   task automatic verify(string req, int n, int b);
      chk(req, nlog - b, n);
      for (int i = 0; i < n; i++) begin
         if (b + i < nlog) begin
            chk(req, log_ch[b + i], bch[eo[i]]);
            chk({req, " R11 stime"}, log_st[b + i], bst[eo[i]]);
            exp_res[eo[i]] = dat(b + i);
         end
      end
   endtask

   initial begin : stim
      int b, c, f;
      for (int i = 0; i < 64; i++) exp_res[i] = 0;
      cyc(4);
      // R1 reset state
      chk("R1 req", int'(conv_req), 0);
      chk("R1 flags", int'({cmpl_flag, pause_flag, ovr_flag, irq}), 0);
      chk("R1 ptr", int'(q1_ptr) + int'(q2_ptr), 0);
      @(negedge clk); rst_n = 1'b1;
      cyc(2);
      chk("R1 req after release", int'(conv_req), 0);
      for (int a = 0; a < 64; a++) wr(a, (a * 7 + 1) % 63, a % 4, 0);

      // R2: software start, end code at 5
      q2_begin = 6'd32; cf_ie = 2'b01;
      wr(5, 63, 0, 0);
      b = nlog; go(0); wait_cmpl(0);
      for (int i = 0; i < 5; i++) eo[i] = i;
      verify("R2 order", 5, b);
      chk("R2 ptr back to 0", int'(q1_ptr), 0);
      chk("R12 irq on complete", int'(irq[0]), 1);
      clr(0);
      chk("R12 clear", int'({cmpl_flag[0], irq[0]}), 0);

      // R4: pause at entry 2
      wr(2, bch[2], bst[2], 1);
      pf_ie = 2'b01; cf_ie = 2'b00;
      b = nlog; go(0);
      begin : wp
         int t = 0;
         while (!pause_flag[0] && t < 500) begin @(negedge clk); t++; end
      end
      cyc(20);
      chk("R4 stopped after pause", nlog - b, 3);
      chk("R4 ptr next", int'(q1_ptr), 3);
      chk("R12 irq on pause", int'(irq[0]), 1);
      chk("R4 no request", int'(conv_req), 0);
      go(0); wait_cmpl(0);
      for (int i = 0; i < 5; i++) eo[i] = i;
      verify("R4 resume", 5, b);
      wr(2, bch[2], bst[2], 0);
      clr(0); pf_ie = 2'b00;

      // R9: overrun
      b = nlog; go(0); cyc(2); go(0);
      wait_cmpl(0); cyc(20);
      verify("R9 sequence unchanged", 5, b);
      chk("R9 overrun flag", int'(ovr_flag[0]), 1);
      chk("R9 other queue", int'(ovr_flag[1]), 0);
      clr(0);

      // R3: region boundaries
      wr(5, (5 * 7 + 1) % 63, 1, 0);
      wr(10, 63, 0, 0);
      q2_begin = 6'd4;
      b = nlog; go(0); wait_cmpl(0);
      for (int i = 0; i < 4; i++) eo[i] = i;
      verify("R3 q1 ends at boundary", 4, b);
      b = nlog; go(1); wait_cmpl(1);
      for (int i = 0; i < 6; i++) eo[i] = 4 + i;
      verify("R3 q2 from boundary", 6, b);
      chk("R3 q2 ptr", int'(q2_ptr), 0);
      clr(1);
      q2_begin = 6'd60;
      b = nlog; go(1); wait_cmpl(1);
      for (int i = 0; i < 4; i++) eo[i] = 60 + i;
      verify("R3 q2 ends at top", 4, b);
      clr(0); clr(1);

      // R5: priority
      wr(10, (10 * 7 + 1) % 63, 2, 0);
      wr(3, 63, 0, 0);
      wr(22, 63, 0, 0);
      q2_begin = 6'd16;
      b = nlog; go(1);
      while (!conv_req) @(negedge clk);
      go(0);
      wait_cmpl(1); wait_cmpl(0);
      eo[0] = 16; eo[1] = 0; eo[2] = 1; eo[3] = 2;
      for (int i = 0; i < 5; i++) eo[4 + i] = 17 + i;
      verify("R5 preempt order", 9, b);
      clr(0); clr(1);

      // R6: edge mode on queue 2
      q_mode = 4'b0100;
      b = nlog;
      @(negedge clk); ext_trig[1] = 1'b1;
      wait_cmpl(1); cyc(40);
      for (int i = 0; i < 6; i++) eo[i] = 16 + i;
      verify("R6 one run per edge", 6, b);
      go(1); cyc(40);
      chk("R6 sw_go ignored", nlog - b, 6);
      @(negedge clk); ext_trig[1] = 1'b0;
      cyc(5); clr(1);
      @(negedge clk); ext_trig[1] = 1'b1;
      wait_cmpl(1); cyc(5);
      chk("R6 second edge", nlog - b, 12);
      @(negedge clk); ext_trig[1] = 1'b0;
      clr(1);

      // R7: gate mode on queue 1 (entries 0..2)
      q_mode = 4'b0010;
      b = nlog;
      @(negedge clk); ext_trig[0] = 1'b1;
      while (nlog - b < 7) @(negedge clk);
      ext_trig[0] = 1'b0;
      c = nlog - b;
      cyc(40);
      f = nlog - b;
      chk("R7 stops after in-flight", int'(f <= c + 1), 1);
      chk("R7 restarted after complete", int'(cmpl_flag[0]), 1);
      cyc(30);
      chk("R7 stays stopped", nlog - b, f);
      for (int i = 0; i < f; i++) eo[i] = i % 3;
      verify("R7 cyclic order", f, b);
      clr(0);

      // R8: interval timer on queue 2
      q_mode = 4'b1110;
      tmr_period = 16'd80;
      b = nlog;
      cyc(800);
      q_mode = 4'b0010;
      cyc(80);
      c = nlog - b;
      chk("R8 whole runs", c % 6, 0);
      chk("R8 run count", int'(c / 6 >= 8 && c / 6 <= 11), 1);
      chk("R8 no overrun", int'(ovr_flag[1]), 0);
      for (int i = 0; i < c; i++) eo[i] = 16 + (i % 6);
      verify("R8 order", c, b);
      b = nlog;
      @(negedge clk); tmr_period = 16'd8; q_mode = 4'b1110;
      cyc(100);
      q_mode = 4'b0010; tmr_period = 16'd0;
      cyc(80);
      chk("R9 timer overrun", int'(ovr_flag[1]), 1);
      c = nlog - b;
      chk("R8 whole runs fast", c % 6, 0);
      for (int i = 0; i < c; i++) eo[i] = 16 + (i % 6);
      verify("R8 fast order", c, b);
      clr(1);
      chk("R12 clear all", int'({cmpl_flag[1], pause_flag[1], ovr_flag[1]}), 0);

      // R10: all results in all three alignments
      for (int a = 0; a < 64; a++) begin
         for (int fm = 0; fm < 3; fm++) begin
            int e;
            @(negedge clk);
            rd_addr = 6'(a); rd_fmt = 2'(fm);
            #1;
            if (fm == 0) e = exp_res[a];
            else if (fm == 1) e = exp_res[a] * 64;
            else e = ((exp_res[a] - 512) * 64) & 16'hFFFF;
            chk($sformatf("R10 addr %0d fmt %0d", a, fm), int'(rd_data), e);
         end
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule